// File: doc/BRIEF.md
# RDS Bit Position Down-Counter with Zero-Count Interrupt

This block counts down the bit positions of an RDS data stream so that the host is told at a bit interval it picks. It takes one step for each syndrome calculation. A calculation is started either by a rising edge on the demodulator's data clock or by a software recalculation strobe. When the count runs out, the block raises a one-cycle interrupt pulse and also latches a sticky flag. The host can then poll the valid-syndrome result or check a block boundary at exactly that bit.

A sync-mode input sets the period the counter reloads itself with once it runs out. Bit-sync gives an interrupt on every bit. Block-sync gives one every 26 bits, which is one RDS block. Group-sync gives one every 104 bits, which is one group and serves as a slow standby tick. The host can write any value at any time through a load-value/load-strobe pair. The live count is always visible, so software can measure how many bits lie between two valid syndromes and confirm the 26-bit spacing. All pins are plain control and status pins. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `rds_bitpos_counter`

## Requirements
- R1: After reset the count reads 1, and both the interrupt pulse and the sticky flag are 0.
- R2: A calculation event is one of two things. The first is a cycle in which `dclk_in` is high after being sampled low in the previous cycle. The second is a cycle in which `recalc` is high. Both in the same cycle count as a single event, and holding `dclk_in` high gives no further events.
- R3: On a calculation event with no load and a count above 1, the count drops by exactly one on that clock edge, and no interrupt is raised.
- R4: On a calculation event with no load and a count of 1, `irq_pulse` is raised and the count reloads with the mode period. The `sync_mode` encodings are 0 = bit-sync (period 1), 1 = block-sync (period 26), 2 = group-sync (period 104) and 3 = group-sync (period 104).
- R5: While the count is 0, every calculation event without a load raises `irq_pulse`, and the count stays 0.
- R6: `load_en` writes `load_val` (any 7-bit value, including 0 and 127) into the count on that edge. It takes priority over a calculation event in the same cycle, and no interrupt is raised in that cycle.
- R7: `irq_pulse` is high for exactly the one cycle that follows each interrupting calculation event. It is high at no other time.
- R8: `irq_flag` sets on the same edge that raises `irq_pulse` and stays set until a cycle with `irq_clr` high. If a set and a clear arrive in the same cycle, the set wins.
- R9: With neither a calculation event nor a load, the count and the pulse do not change. A change of `sync_mode` alone leaves the count untouched and only affects the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk_in | input | 1 | Demodulator data clock level, sampled by `clk` |
| recalc | input | 1 | Software syndrome recalculation strobe |
| sync_mode | input | 2 | Reload period select (0 bit, 1 block, 2 or 3 group) |
| load_en | input | 1 | Host load strobe |
| load_val | input | 7 | Value written by a load |
| irq_clr | input | 1 | Write-1 clear of the sticky flag |
| count | output | 7 | Current count readback |
| irq_pulse | output | 1 | One-cycle zero-count interrupt |
| irq_flag | output | 1 | Sticky zero-count interrupt flag |

## Verification
Every result is due on the first rising clock edge after the stimulus is presented: the count, the pulse and the flag are all registered one level behind the inputs, and the data-clock edge is detected against the previous sampled level without extra delay at the default setting. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares the three outputs on the next falling edge. Only then does it present the next stimulus, so every comparison sees exactly one edge of effect. The long block-sync and group-sync walks follow the same one-edge rule for each step, so the pulse is shown to appear on the 26th or 104th step and on no earlier one.

// File: rtl/rbc_pkg.sv
`timescale 1ns/1ps
package rbc_pkg;

  // Sync-mode encodings seen on the sync_mode pin.
  typedef enum logic [1:0] {
    SYNC_BIT       = 2'd0,
    SYNC_BLOCK     = 2'd1,
    SYNC_GROUP     = 2'd2,
    SYNC_GROUP_ALT = 2'd3
  } sync_mode_e;

  localparam int unsigned RBC_CNT_W   = 7;
  localparam int unsigned RBC_BIT_PER = 1;
  localparam int unsigned RBC_BLK_PER = 26;
  localparam int unsigned RBC_GRP_PER = 104;

endpackage

// File: rtl/rbc_calc_src.sv
`timescale 1ns/1ps
// Produces one calculation event per rising data-clock edge or recalc strobe.
module rbc_calc_src #(
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dclk_in,
  input  logic recalc,
  output logic calc_evt
);

  logic dclk_s;
  logic dclk_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign dclk_s = dclk_in;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '0;
        end else begin
          chain[0] <= dclk_in;
          for (int i = 1; i < int'(SYNC_STAGES); i++) begin
            chain[i] <= chain[i-1];
          end
        end
      end
      assign dclk_s = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dclk_q <= 1'b0;
    else        dclk_q <= dclk_s;
  end

  // A strobe and an edge in the same cycle collapse into one event.
  assign calc_evt = (dclk_s & ~dclk_q) | recalc;

endmodule

// File: rtl/rbc_period_sel.sv
`timescale 1ns/1ps
// Maps the sync mode onto the reload period.
module rbc_period_sel
  import rbc_pkg::*;
#(
  parameter int unsigned CNT_W   = RBC_CNT_W,
  parameter int unsigned BIT_PER = RBC_BIT_PER,
  parameter int unsigned BLK_PER = RBC_BLK_PER,
  parameter int unsigned GRP_PER = RBC_GRP_PER
) (
  input  logic [1:0]       sync_mode,
  output logic [CNT_W-1:0] period
);

  localparam logic [CNT_W-1:0] P_BIT = CNT_W'(BIT_PER);
  localparam logic [CNT_W-1:0] P_BLK = CNT_W'(BLK_PER);
  localparam logic [CNT_W-1:0] P_GRP = CNT_W'(GRP_PER);

  always_comb begin
    case (sync_mode_e'(sync_mode))
      SYNC_BIT:   period = P_BIT;
      SYNC_BLOCK: period = P_BLK;
      default:    period = P_GRP;
    endcase
  end

endmodule

// File: rtl/rbc_down_cnt.sv
`timescale 1ns/1ps
// Down-counter: load has priority, then step / reload / zero hold.
module rbc_down_cnt #(
  parameter int unsigned CNT_W   = 7,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             calc_evt,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             hit,
  output logic             pulse
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = count;
    hit     = 1'b0;
    if (load_en) begin
      cnt_nxt = load_val;
    end else if (calc_evt) begin
      if (count == ZERO) begin
        hit = 1'b1;
      end else if (count == ONE) begin
        hit     = 1'b1;
        cnt_nxt = period;
      end else begin
        cnt_nxt = count - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= CNT_W'(RST_VAL);
      pulse <= 1'b0;
    end else begin
      count <= cnt_nxt;
      pulse <= hit;
    end
  end

endmodule

// File: rtl/rbc_irq_flag.sv
`timescale 1ns/1ps
// Sticky interrupt flag, write-1 clear, set wins.
module rbc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set_i | (flag & ~clr_i);
  end

endmodule

// File: rtl/rds_bitpos_counter.sv
`timescale 1ns/1ps
module rds_bitpos_counter
  import rbc_pkg::*;
#(
  parameter int unsigned CNT_W       = RBC_CNT_W,
  parameter int unsigned BIT_PER     = RBC_BIT_PER,
  parameter int unsigned BLK_PER     = RBC_BLK_PER,
  parameter int unsigned GRP_PER     = RBC_GRP_PER,
  parameter int unsigned RST_VAL     = RBC_BIT_PER,
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dclk_in,
  input  logic             recalc,
  input  logic [1:0]       sync_mode,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count,
  output logic             irq_pulse,
  output logic             irq_flag
);

  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  initial begin
    if (GRP_PER > CNT_MAX || BLK_PER > CNT_MAX || BIT_PER > CNT_MAX)
      $error("reload period does not fit counter width");
  end

  logic             calc_evt;
  logic [CNT_W-1:0] period;
  logic             hit;

  rbc_calc_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .dclk_in  (dclk_in),
    .recalc   (recalc),
    .calc_evt (calc_evt)
  );

  rbc_period_sel #(
    .CNT_W(CNT_W), .BIT_PER(BIT_PER), .BLK_PER(BLK_PER), .GRP_PER(GRP_PER)
  ) u_per (
    .sync_mode (sync_mode),
    .period    (period)
  );

  rbc_down_cnt #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_val (load_val),
    .calc_evt (calc_evt),
    .period   (period),
    .count    (count),
    .hit      (hit),
    .pulse    (irq_pulse)
  );

  rbc_irq_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (hit),
    .clr_i (irq_clr),
    .flag  (irq_flag)
  );

endmodule

// File: rtl/rbc_checker.sv
`timescale 1ns/1ps
module rbc_checker #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_en,
  input logic [CNT_W-1:0] load_val,
  input logic             calc_evt,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] count,
  input logic             irq_pulse,
  input logic             irq_flag,
  input logic             irq_clr
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (count == $past(load_val)) && !irq_pulse);

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && calc_evt && count > ONE) |=> (count == $past(count) - ONE) && !irq_pulse);

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && calc_evt && count == ONE) |=> irq_pulse && (count == $past(period)));

  a_r5_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && calc_evt && count == '0) |=> irq_pulse && (count == '0));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !calc_evt) |=> $stable(count) && !irq_pulse);

  a_r8_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_flag);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && (load_en || !calc_evt || count > ONE)) |=> !irq_flag);

endmodule

bind rds_bitpos_counter rbc_checker #(.CNT_W(CNT_W)) u_rbc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_en   (load_en),
  .load_val  (load_val),
  .calc_evt  (calc_evt),
  .period    (period),
  .count     (count),
  .irq_pulse (irq_pulse),
  .irq_flag  (irq_flag),
  .irq_clr   (irq_clr)
);

// File: tb/rds_bitpos_counter_bench.sv
`timescale 1ns/1ps
module rds_bitpos_counter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dclk_in = 1'b0;
  logic       recalc = 1'b0;
  logic [1:0] sync_mode = 2'd0;
  logic       load_en = 1'b0;
  logic [6:0] load_val = '0;
  logic       irq_clr = 1'b0;
  logic [6:0] count;
  logic       irq_pulse;
  logic       irq_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rds_bitpos_counter u_rds_bitpos_counter (
    .clk(clk), .rst_n(rst_n), .dclk_in(dclk_in), .recalc(recalc),
    .sync_mode(sync_mode), .load_en(load_en), .load_val(load_val),
    .irq_clr(irq_clr), .count(count), .irq_pulse(irq_pulse), .irq_flag(irq_flag)
  );

  typedef struct packed {
    logic [4:0] rq;
    logic       ld;
    logic [6:0] val;
    logic       dc;
    logic       rc;
    logic [1:0] md;
    logic       clr;
    logic [6:0] ec;
    logic       ep;
    logic       ef;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{5'd2, 1'b0, 7'd0,   1'b1, 1'b0, 2'd0, 1'b0, 7'd1,   1'b1, 1'b1},
    '{5'd2, 1'b0, 7'd0,   1'b1, 1'b0, 2'd0, 1'b0, 7'd1,   1'b0, 1'b1},
    '{5'd8, 1'b0, 7'd0,   1'b0, 1'b0, 2'd0, 1'b1, 7'd1,   1'b0, 1'b0},
    '{5'd2, 1'b0, 7'd0,   1'b0, 1'b1, 2'd0, 1'b0, 7'd1,   1'b1, 1'b1},
    '{5'd6, 1'b1, 7'd5,   1'b0, 1'b0, 2'd0, 1'b1, 7'd5,   1'b0, 1'b0},
    '{5'd3, 1'b0, 7'd0,   1'b1, 1'b0, 2'd1, 1'b0, 7'd4,   1'b0, 1'b0},
    '{5'd3, 1'b0, 7'd0,   1'b0, 1'b1, 2'd1, 1'b0, 7'd3,   1'b0, 1'b0},
    '{5'd2, 1'b0, 7'd0,   1'b1, 1'b1, 2'd1, 1'b0, 7'd2,   1'b0, 1'b0},
    '{5'd9, 1'b0, 7'd0,   1'b0, 1'b0, 2'd1, 1'b0, 7'd2,   1'b0, 1'b0},
    '{5'd3, 1'b0, 7'd0,   1'b0, 1'b1, 2'd1, 1'b0, 7'd1,   1'b0, 1'b0},
    '{5'd4, 1'b0, 7'd0,   1'b0, 1'b1, 2'd1, 1'b0, 7'd26,  1'b1, 1'b1},
    '{5'd6, 1'b1, 7'd3,   1'b0, 1'b1, 2'd1, 1'b0, 7'd3,   1'b0, 1'b1},
    '{5'd8, 1'b0, 7'd0,   1'b0, 1'b1, 2'd1, 1'b1, 7'd2,   1'b0, 1'b0},
    '{5'd9, 1'b0, 7'd0,   1'b0, 1'b1, 2'd2, 1'b0, 7'd1,   1'b0, 1'b0},
    '{5'd8, 1'b0, 7'd0,   1'b0, 1'b1, 2'd2, 1'b1, 7'd104, 1'b1, 1'b1},
    '{5'd6, 1'b1, 7'd1,   1'b0, 1'b0, 2'd3, 1'b0, 7'd1,   1'b0, 1'b1},
    '{5'd4, 1'b0, 7'd0,   1'b0, 1'b1, 2'd3, 1'b1, 7'd104, 1'b1, 1'b1},
    '{5'd6, 1'b1, 7'd0,   1'b0, 1'b0, 2'd3, 1'b1, 7'd0,   1'b0, 1'b0},
    '{5'd5, 1'b0, 7'd0,   1'b0, 1'b1, 2'd3, 1'b0, 7'd0,   1'b1, 1'b1},
    '{5'd5, 1'b0, 7'd0,   1'b0, 1'b1, 2'd3, 1'b1, 7'd0,   1'b1, 1'b1},
    '{5'd9, 1'b0, 7'd0,   1'b0, 1'b0, 2'd3, 1'b0, 7'd0,   1'b0, 1'b1},
    '{5'd6, 1'b1, 7'd127, 1'b0, 1'b0, 2'd0, 1'b0, 7'd127, 1'b0, 1'b1},
    '{5'd3, 1'b0, 7'd0,   1'b1, 1'b0, 2'd0, 1'b0, 7'd126, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  // Drive on a falling edge, let one rising edge act, return on the next falling edge.
  task automatic step(input logic ld, input logic [6:0] v, input logic dc,
                      input logic rc, input logic [1:0] md, input logic clr);
    load_en = ld; load_val = v; dclk_in = dc; recalc = rc; sync_mode = md; irq_clr = clr;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "count", int'(count), 1);
    chk("R1", "pulse", int'(irq_pulse), 0);
    chk("R1", "flag",  int'(irq_flag), 0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d(vec %0d)", VECS[i].rq, i);
      step(VECS[i].ld, VECS[i].val, VECS[i].dc, VECS[i].rc, VECS[i].md, VECS[i].clr);
      chk(rq, "count", int'(count),     int'(VECS[i].ec));
      chk(rq, "pulse", int'(irq_pulse), int'(VECS[i].ep));
      chk(rq, "flag",  int'(irq_flag),  int'(VECS[i].ef));
    end

    // R4 R7: block-sync walk, pulse only on the 26th step
    step(1'b1, 7'd1, 1'b0, 1'b0, 2'd1, 1'b1);
    step(1'b0, 7'd0, 1'b0, 1'b1, 2'd1, 1'b0);
    chk("R4", "block first reload count", int'(count), 26);
    for (int k = 1; k <= 26; k++) begin
      step(1'b0, 7'd0, 1'b0, 1'b1, 2'd1, 1'b0);
      chk("R7", "block walk pulse", int'(irq_pulse), (k == 26) ? 1 : 0);
      chk("R3", "block walk count", int'(count), (k == 26) ? 26 : 26 - k);
    end

    // R4 R7: group-sync walk, pulse only on the 104th step
    step(1'b1, 7'd1, 1'b0, 1'b0, 2'd2, 1'b0);
    step(1'b0, 7'd0, 1'b0, 1'b1, 2'd2, 1'b0);
    chk("R4", "group first reload count", int'(count), 104);
    for (int k = 1; k <= 104; k++) begin
      step(1'b0, 7'd0, 1'b0, 1'b1, 2'd2, 1'b0);
      chk("R7", "group walk pulse", int'(irq_pulse), (k == 104) ? 1 : 0);
    end
    chk("R4", "group reload count", int'(count), 104);

    // R9: mode change alone leaves the count untouched
    step(1'b1, 7'd10, 1'b0, 1'b0, 2'd0, 1'b0);
    step(1'b0, 7'd0, 1'b0, 1'b0, 2'd2, 1'b0);
    chk("R9", "count after mode change", int'(count), 10);

    // R2: held-high data clock yields one step only
    step(1'b0, 7'd0, 1'b1, 1'b0, 2'd2, 1'b0);
    step(1'b0, 7'd0, 1'b1, 1'b0, 2'd2, 1'b0);
    step(1'b0, 7'd0, 1'b1, 1'b0, 2'd2, 1'b0);
    chk("R2", "count with held dclk", int'(count), 9);

    // R1: reset in mid-count
    step(1'b1, 7'd50, 1'b0, 1'b1, 2'd0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "count after mid reset", int'(count), 1);
    chk("R1", "flag after mid reset", int'(irq_flag), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule